// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Result Port

This block is a cycle-level model of the digital serial port of a delta-sigma converter. It can stand in for the converter as a peer in a testbench or as a behavioural replacement. Everything runs on one system clock. The serial clock, data-in and chip-select pins are sampled on that clock, and their edges are found by comparing each sample with the one before. After reset, a power-on period runs first. At the end of that period the level on the serial-clock pin fixes the clock mode: if the pin is low, the external-clock mode is used; otherwise the internal-clock mode is flagged.

A conversion is a timed wait of a programmable number of system clocks. While it runs, the data-out pin reads 1. When the conversion ends, the pin drops to 0 and, in the same cycle, the 24-bit signed result is loaded into a 32-bit frame. Falling serial-clock edges walk this frame out onto data-out. Rising edges capture five configuration bits from data-in. The 32nd falling edge does three things: it makes the captured configuration active, drives data-out high and starts the next conversion.

Raising chip select while a result is waiting abandons the frame. The frame is rewound to its first bit and the bits captured so far are discarded.

Top module: `dsadc_serial_port`

## Requirements
- R1: After reset is released, the power-on period lasts POR_CYCLES clocks, and sdo_oe_o is 0 throughout it. When the period ends, ext_mode_o becomes 1 if sck_i is low at that moment and 0 otherwise. ext_mode_o then holds until the next reset.
- R2: A conversion begins at the end of the power-on period and again after each completed frame. During a conversion, sdo_o reads 1 for exactly CONV_CYCLES clocks.
- R3: When a conversion ends, sdo_o goes to 0 in the same clock, and res_i is captured into the frame at that clock.
- R4: The frame is sent MSB first in this order: a 0 status bit, a 0 filler bit, a sign bit (1 when res_i[23] is 0), the 24 result bits from bit 23 down to bit 0, and five 0 pad bits.
- R5: Each falling serial-clock edge seen while a result is waiting moves sdo_o to the next frame bit. The new bit appears in the clock where the edge is detected.
- R6: The first five rising serial-clock edges of a frame sample sdi_i. The first sample becomes cfg_o[4] and the fifth becomes cfg_o[0].
- R7: cfg_o changes only at the 32nd falling edge of a frame. Before that edge it keeps its previous value; cfg_o is 0 after reset.
- R8: At the 32nd falling edge, sdo_o returns to 1 and a new conversion starts.
- R9: Serial-clock edges during a conversion have no effect. The next frame still starts at its first bit.
- R10: If cs_n_i is high while a result is waiting, the frame restarts from its first bit and the configuration bits captured so far are discarded, leaving cfg_o unchanged. If this happens in the same clock as a falling edge, the restart wins.
- R11: After the power-on period, sdo_oe_o is always 1 in external-clock mode. In internal-clock mode it is the inverse of cs_n_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock level, sampled on clk |
| sdi_i | input | 1 | Serial configuration data in |
| cs_n_i | input | 1 | Active-low chip select |
| res_i | input | 24 | Signed conversion result from the conversion stub |
| sdo_o | output | 1 | Serial data out: conversion status or frame bit |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high impedance |
| ext_mode_o | output | 1 | 1 when external-clock mode was selected |
| cfg_o | output | 5 | Active configuration word |

## Verification
The 32nd falling edge lands in the same clock as configuration activation and the conversion restart. The bench samples one bit before that edge and expects the old cfg_o. In the clock after the edge it expects the new word together with sdo_o at 1.

A chip-select abort can also coincide with a shift. The partial-frame test raises cs_n_i in the same clock that it drops the serial clock. It then expects the status bit 0 on sdo_o, an unchanged cfg_o, and a following full frame whose bits all match the result captured for it.

// File: rtl/dsadc_port_pkg.sv
package dsadc_port_pkg;

    localparam int RES_W   = 24;
    localparam int FRAME_W = 32;
    localparam int CFG_W   = 5;
    localparam int PAD_W   = FRAME_W - 3 - RES_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int RCNT_W  = $clog2(CFG_W + 1);

    typedef enum logic [1:0] {
        PH_POR   = 2'd0,
        PH_CONV  = 2'd1,
        PH_READY = 2'd2
    } phase_t;

    // Order of fields is the order bits leave the pin
    typedef struct packed {
        logic             eoc;
        logic             filler;
        logic             sign;
        logic [RES_W-1:0] data;
        logic [PAD_W-1:0] pad;
    } frame_t;

    function automatic frame_t build_frame(input logic [RES_W-1:0] r);
        frame_t f;
        f.eoc    = 1'b0;
        f.filler = 1'b0;
        f.sign   = ~r[RES_W-1];
        f.data   = r;
        f.pad    = '0;
        return f;
    endfunction

endpackage

// File: rtl/dsadc_por_sel.sv
module dsadc_por_sel #(
    parameter int POR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    output logic por_active_o,
    output logic por_done_o,
    output logic ext_mode_o
);
    localparam int PW = $clog2(POR_CYCLES + 1);

    logic [PW-1:0] cnt;

    assign por_done_o = por_active_o && (cnt == PW'(POR_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            por_active_o <= 1'b1;
            ext_mode_o   <= 1'b0;
        end else if (por_done_o) begin
            por_active_o <= 1'b0;
            ext_mode_o   <= ~sck_i;
        end else if (por_active_o) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dsadc_conv_timer.sv
module dsadc_conv_timer #(
    parameter int CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          run;

    assign done_o = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start_i) begin
            run <= 1'b1;
            cnt <= CW'(CONV_CYCLES - 1);
        end else if (done_o) begin
            run <= 1'b0;
        end else if (run) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dsadc_shifter.sv
module dsadc_shifter
    import dsadc_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  frame_t           frame_i,
    input  logic             shift_en_i,
    input  logic             sck_rise_i,
    input  logic             sck_fall_i,
    input  logic             sdi_i,
    input  logic             abort_i,
    output logic             sdo_bit_o,
    output logic             frame_done_o,
    output logic [CFG_W-1:0] cfg_cap_o
);
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] hold;
    logic [CNT_W-1:0]   bit_cnt;
    logic [RCNT_W-1:0]  rise_cnt;

    assign sdo_bit_o    = shreg[FRAME_W-1];
    assign frame_done_o = shift_en_i && !abort_i && sck_fall_i
                          && (bit_cnt == CNT_W'(FRAME_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            hold      <= '0;
            bit_cnt   <= '0;
            rise_cnt  <= '0;
            cfg_cap_o <= '0;
        end else if (load_i) begin
            shreg    <= frame_i;
            hold     <= frame_i;
            bit_cnt  <= '0;
            rise_cnt <= '0;
        end else if (abort_i) begin
            shreg    <= hold;
            bit_cnt  <= '0;
            rise_cnt <= '0;
        end else if (shift_en_i) begin
            if (sck_rise_i && (rise_cnt < RCNT_W'(CFG_W))) begin
                cfg_cap_o <= {cfg_cap_o[CFG_W-2:0], sdi_i};
                rise_cnt  <= rise_cnt + 1'b1;
            end
            if (sck_fall_i) begin
                shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                bit_cnt <= frame_done_o ? '0 : bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsadc_serial_port.sv
module dsadc_serial_port
    import dsadc_port_pkg::*;
#(
    parameter int POR_CYCLES  = 64,
    parameter int CONV_CYCLES = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_i,
    input  logic             sdi_i,
    input  logic             cs_n_i,
    input  logic [RES_W-1:0] res_i,
    output logic             sdo_o,
    output logic             sdo_oe_o,
    output logic             ext_mode_o,
    output logic [CFG_W-1:0] cfg_o
);
    logic       sck_q;
    logic       sck_rise;
    logic       sck_fall;
    phase_t     phase;
    logic       por_active;
    logic       por_done;
    logic       conv_done;
    logic       frame_done;
    logic       conv_start;
    logic       sdo_bit;
    logic       in_ready;
    logic       abort;
    logic [CFG_W-1:0] cfg_cap;

    // Edge detection of the sampled serial clock
    always_ff @(posedge clk) begin
        sck_q <= sck_i;
    end
    assign sck_rise = sck_i & ~sck_q;
    assign sck_fall = ~sck_i & sck_q;

    assign in_ready   = (phase == PH_READY);
    assign abort      = in_ready & cs_n_i;
    assign conv_start = por_done | frame_done;

    dsadc_por_sel #(.POR_CYCLES(POR_CYCLES)) por_i (
        .clk          (clk),
        .rst          (rst),
        .sck_i        (sck_i),
        .por_active_o (por_active),
        .por_done_o   (por_done),
        .ext_mode_o   (ext_mode_o)
    );

    dsadc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (conv_start),
        .done_o  (conv_done)
    );

    dsadc_shifter shift_i (
        .clk          (clk),
        .rst          (rst),
        .load_i       (conv_done),
        .frame_i      (build_frame(res_i)),
        .shift_en_i   (in_ready),
        .sck_rise_i   (sck_rise),
        .sck_fall_i   (sck_fall),
        .sdi_i        (sdi_i),
        .abort_i      (abort),
        .sdo_bit_o    (sdo_bit),
        .frame_done_o (frame_done),
        .cfg_cap_o    (cfg_cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_POR;
            cfg_o <= '0;
        end else begin
            unique case (phase)
                PH_POR:   if (por_done)   phase <= PH_CONV;
                PH_CONV:  if (conv_done)  phase <= PH_READY;
                PH_READY: if (frame_done) phase <= PH_CONV;
                default:                  phase <= PH_POR;
            endcase
            if (frame_done) begin
                cfg_o <= cfg_cap;
            end
        end
    end

    assign sdo_o    = in_ready ? sdo_bit : 1'b1;
    assign sdo_oe_o = !por_active && (ext_mode_o || !cs_n_i);
endmodule

// File: rtl/dsadc_serial_port_chk.sv
module dsadc_serial_port_chk
    import dsadc_port_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sdo_o,
    input logic             sdo_oe_o,
    input logic             ext_mode_o,
    input logic [CFG_W-1:0] cfg_o,
    input logic             cs_n_i,
    input logic             por_active,
    input phase_t           phase,
    input logic             conv_done,
    input logic             frame_done
);
    // R1
    por_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        por_active |-> !sdo_oe_o);

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !por_active |=> $stable(ext_mode_o));

    // R11
    ext_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!por_active && ext_mode_o) |-> sdo_oe_o);

    // R11
    int_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (!por_active && !ext_mode_o && cs_n_i) |-> !sdo_oe_o);

    // R3
    eoc_fall_chk: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !sdo_o);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (sdo_o && phase == PH_CONV));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(cfg_o));

    // R9
    conv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CONV) |-> !frame_done);
endmodule

bind dsadc_serial_port dsadc_serial_port_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .ext_mode_o (ext_mode_o),
    .cfg_o      (cfg_o),
    .cs_n_i     (cs_n_i),
    .por_active (por_active),
    .phase      (phase),
    .conv_done  (conv_done),
    .frame_done (frame_done)
);

// File: tb/dsadc_serial_port_tb_top.sv
`timescale 1ns/1ps
module dsadc_serial_port_tb_top;
    localparam int POR_N  = 64;
    localparam int CONV_N = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        cs_n = 1'b0;
    logic [23:0] res = '0;
    logic        sdo;
    logic        sdo_oe;
    logic        ext_mode;
    logic [4:0]  cfg;

    int checks = 0;
    int errors = 0;
    logic mon_take = 1'b0;
    logic exp_q[$];

    always #2 clk = ~clk;

    dsadc_serial_port #(.POR_CYCLES(POR_N), .CONV_CYCLES(CONV_N)) dut_i (
        .clk(clk), .rst(rst), .sck_i(sck), .sdi_i(sdi), .cs_n_i(cs_n),
        .res_i(res), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
        .ext_mode_o(ext_mode), .cfg_o(cfg)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: pops one expected bit per request and compares with the pin
    always @(negedge clk) begin
        if (mon_take) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R5 queue empty", 32'(sdo), 32'hx);
            end else begin
                logic e;
                e = exp_q.pop_front();
                check(sdo === e, "R4/R5 frame bit", 32'(sdo), 32'(e));
            end
        end
    end

    task automatic wait_ready();
        while (sdo !== 1'b0) @(negedge clk);
    endtask

    // Drives n serial clock periods; cfg bits go out on the first rises
    task automatic clock_bits(input int n, input logic [4:0] c,
                              input bit abort_last);
        for (int i = 0; i < n; i++) begin
            tick();
            mon_take = 1'b1;
            tick();
            mon_take = 1'b0;
            sck = 1'b1;
            sdi = (i < 5) ? c[4 - i] : 1'b0;
            tick();
            tick();
            sck = 1'b0;
            if (abort_last && i == n - 1) cs_n = 1'b1;
            tick();
        end
    endtask

    // Driver: queues the expected frame, then clocks it out
    task automatic run_frame(input logic [23:0] r, input logic [4:0] c,
                             input logic [4:0] prev);
        logic [31:0] f;
        f = {1'b0, 1'b0, ~r[23], r, 5'b00000};
        for (int i = 0; i < 32; i++) exp_q.push_back(f[31 - i]);
        exp_q.push_back(1'b1);
        clock_bits(31, c, 1'b0);
        // R7: before the 32nd fall the old word is still active
        check(cfg == prev, "R7 cfg before last edge", 32'(cfg), 32'(prev));
        clock_bits(1, c, 1'b0);
        tick();
        mon_take = 1'b1;
        tick();
        mon_take = 1'b0;
        // R6: captured bits active after the 32nd fall
        check(cfg == c, "R6 cfg after frame", 32'(cfg), 32'(c));
        // R8: pin high again, conversion restarted
        check(sdo === 1'b1, "R8 restart", 32'(sdo), 32'h1);
    endtask

    task automatic drop_partial(input int n, input logic [4:0] c);
        for (int i = 0; i < n; i++) exp_q.push_back(1'b0);
        exp_q.delete();
        // the abort is raised in the same clock as the last falling edge
        mon_take = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick();
            tick();
            sck = 1'b1;
            sdi = (i < 5) ? c[4 - i] : 1'b0;
            tick();
            tick();
            sck = 1'b0;
            if (i == n - 1) cs_n = 1'b1;
            tick();
        end
        tick();
        tick();
        cs_n = 1'b0;
        tick();
    endtask

    initial begin
        int pc;
        int cc;
        res = 24'h123456;
        repeat (4) tick();
        check(sdo_oe === 1'b0, "R1 oe in reset", 32'(sdo_oe), 32'h0);
        check(cfg === 5'd0, "R7 cfg reset value", 32'(cfg), 32'h0);
        rst = 1'b0;
        pc = 0;
        @(negedge clk);
        while (sdo_oe !== 1'b1 && pc < 10 * POR_N) begin
            pc++;
            @(negedge clk);
        end
        check(pc == POR_N, "R1 power-on length", 32'(pc), 32'(POR_N));
        cc = 0;
        while (sdo === 1'b1 && cc < 10 * CONV_N) begin
            cc++;
            @(negedge clk);
        end
        check(cc == CONV_N, "R2 conversion length", 32'(cc), 32'(CONV_N));
        check(sdo === 1'b0, "R3 end of conversion", 32'(sdo), 32'h0);
        check(ext_mode === 1'b1, "R1 external mode", 32'(ext_mode), 32'h1);
        check(sdo_oe === 1'b1, "R11 ext drive", 32'(sdo_oe), 32'h1);

        run_frame(24'h123456, 5'b10110, 5'b00000);

        // R9: clock edges during the conversion are ignored
        res = 24'h800001;
        for (int k = 0; k < 6; k++) begin
            tick(); sck = 1'b1; tick(); tick(); sck = 1'b0; tick();
        end
        check(sdo === 1'b1, "R9 still converting", 32'(sdo), 32'h1);
        wait_ready();
        run_frame(24'h800001, 5'b01101, 5'b10110);

        // R10: partial frame, abort coincides with a falling edge
        res = 24'h7FFFFF;
        wait_ready();
        drop_partial(12, 5'b11111);
        #1;
        check(sdo === 1'b0, "R10 frame rewound", 32'(sdo), 32'h0);
        check(cfg == 5'b01101, "R10 cfg unchanged", 32'(cfg), 32'h0d);
        run_frame(24'h7FFFFF, 5'b00011, 5'b01101);

        // R1/R11: serial clock high at power-on end selects internal mode
        rst = 1'b1;
        sck = 1'b1;
        cs_n = 1'b1;
        res = 24'h000000;
        repeat (4) tick();
        rst = 1'b0;
        repeat (POR_N + 5) tick();
        check(ext_mode === 1'b0, "R1 internal mode", 32'(ext_mode), 32'h0);
        check(sdo_oe === 1'b0, "R11 hiz with cs high", 32'(sdo_oe), 32'h0);
        cs_n = 1'b0;
        tick();
        check(sdo_oe === 1'b1, "R11 drive with cs low", 32'(sdo_oe), 32'h1);
        sck = 1'b0;
        wait_ready();
        run_frame(24'h000000, 5'b10001, 5'b00000);
        cs_n = 1'b1;
        tick();
        check(sdo_oe === 1'b0, "R11 hiz after frame", 32'(sdo_oe), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule